// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is one channel of a free-running timer. It observes a counter value shared by all channels, an asynchronous pin input and a one-cycle overflow strobe. It drives a pin output, a channel value register and an interrupt request. A single 8-bit control word chooses among three behaviours. In capture mode a selected pin edge records the counter. In compare mode a counter match sets, clears or toggles the output. In pulse-width mode the overflow starts each period and the match ends it.

Each capture or match sets an event flag. Software clears the flag with a two-step handshake: it first reads the control word while the flag is 1, then writes 0 to the flag bit. If an event arrives between those two steps, the write is ignored, so no event is lost. Simple one-cycle read and write strobes stand in for the processor bus.

Top module: `tmr_chan_unit`

## Requirements
- R1: After reset, the control read-back, the value register, the pin output and the interrupt request are all 0.
- R2: The control word is laid out as bit 7 flag, bit 6 interrupt enable, bits 5:4 mode, bits 3:2 edge/level select, bit 1 toggle-on-overflow and bit 0 max-duty. A write stores bits 6:0 and they read back unchanged. Writing 1 to bit 7 never sets the flag.
- R3: In mode 00 (capture), the edge select picks the active edge of the pin: 01 is rising, 10 is falling, 11 is either edge and 00 is none. The pin passes through a two-flop synchronizer, so the flag reads 1 after the third rising clock edge that follows a pin change.
- R4: On a capture, the counter value is copied into the value register on the same clock edge that sets the flag.
- R5: In mode 01 (compare) and in modes 1x (pulse-width), the flag sets on every clock edge at which the counter equals the value register.
- R6: In compare mode, a match acts on the output according to the edge/level select: 01 toggles it, 10 drives it to 0 and 11 drives it to 1. With select 00, or in capture mode, the pin output is held at 0.
- R7: In compare mode with bit 1 set, each overflow strobe toggles the output. A match in the same cycle takes precedence over the toggle. With bit 1 clear, the overflow strobe has no effect on the output.
- R8: In pulse-width mode, select 10 makes the overflow drive the output to 1 and the match drive it to 0. Select 11 does the reverse. When the overflow and the match fall in the same cycle, the overflow wins.
- R9: In pulse-width mode with bit 0 set, matches leave the output unchanged, so the level set at the period start holds (100% or 0% duty).
- R10: A write with bit 7 at 0 clears the flag only if an earlier read saw the flag at 1 and no event has occurred since that read. Without such a read, the write leaves the flag set.
- R11: An event between the qualifying read and the clearing write cancels the read's qualification, so the flag stays set.
- R12: The interrupt request is 1 exactly when both the flag and the interrupt enable read 1.
- R13: A value-register write strobe loads the written data when no capture occurs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_val | input | W | Shared counter value |
| cnt_ovf | input | 1 | One-cycle counter overflow strobe |
| pin_in | input | 1 | Asynchronous channel pin input |
| reg_rd | input | 1 | Control word read strobe |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 8 | Control word write data |
| reg_rdata | output | 8 | Control word read data |
| val_wr | input | 1 | Value register write strobe |
| val_wdata | input | W | Value register write data |
| val_q | output | W | Value register |
| pin_out | output | 1 | Channel pin output |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the read and write strobes for the control word are never asserted in the same cycle. They also assume that the overflow strobe lasts one cycle and that the pin input is held for at least three clock edges after each change, so the synchronizer delivers every transition. The bench drives strobes one at a time from tasks and holds each pin level for three cycles. It sets the counter value by hand, so each match, capture and overflow falls in a cycle the bench chooses.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

  localparam logic [1:0] MD_CAPTURE = 2'b00;
  localparam logic [1:0] MD_COMPARE = 2'b01;

  // active edge decode for capture: bit 0 enables rising, bit 1 enables falling
  function automatic logic edge_hit(input logic [1:0] sel, input logic rise, input logic fall);
    return (sel[0] & rise) | (sel[1] & fall);
  endfunction

  function automatic logic drive_en(input logic [1:0] mode, input logic [1:0] sel);
    return (mode != MD_CAPTURE) && (sel != 2'b00);
  endfunction

  // next output level for compare and pulse-width behaviour
  function automatic logic next_out(input logic [1:0] mode, input logic [1:0] sel,
                                    input logic tov, input logic maxd,
                                    input logic match, input logic ovf, input logic cur);
    logic nxt;
    nxt = cur;
    if (mode[1]) begin
      if (sel != 2'b00) begin
        if (ovf)                nxt = (sel == 2'b01) ? ~cur : ~sel[0];
        else if (match && !maxd) nxt = (sel == 2'b01) ? ~cur : sel[0];
      end
    end else if (mode == MD_COMPARE) begin
      if (match) begin
        case (sel)
          2'b01:   nxt = ~cur;
          2'b10:   nxt = 1'b0;
          2'b11:   nxt = 1'b1;
          default: nxt = cur;
        endcase
      end else if (ovf && tov) begin
        nxt = ~cur;
      end
    end
    return nxt;
  endfunction

endpackage

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) sh_q[0] <= 1'b0;
          else        sh_q[0] <= pin;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) sh_q[gi] <= 1'b0;
          else        sh_q[gi] <= sh_q[gi-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sh_q[STAGES-1];
  end

  assign rise = sh_q[STAGES-1] & ~prev_q;
  assign fall = ~sh_q[STAGES-1] & prev_q;
endmodule

// File: rtl/tmr_flag_ctrl.sv
module tmr_flag_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic rd,
  input  logic wr,
  input  logic wr_flag_bit,
  output logic flag,
  output logic armed
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else begin
      if (evt)                             flag <= 1'b1;
      else if (wr && !wr_flag_bit && armed) flag <= 1'b0;

      if (evt)             armed <= 1'b0;
      else if (rd && flag) armed <= 1'b1;
      else if (wr)         armed <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_out_ctrl.sv
module tmr_out_ctrl
  import tmr_chan_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic [1:0] sel,
  input  logic       tov,
  input  logic       maxd,
  input  logic       match,
  input  logic       ovf,
  output logic       out_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= next_out(mode, sel, tov, maxd, match, ovf, out_q);
  end
endmodule

// File: rtl/tmr_chan_unit.sv
module tmr_chan_unit
  import tmr_chan_pkg::*;
#(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt_val,
  input  logic         cnt_ovf,
  input  logic         pin_in,
  input  logic         reg_rd,
  input  logic         reg_wr,
  input  logic [7:0]   reg_wdata,
  output logic [7:0]   reg_rdata,
  input  logic         val_wr,
  input  logic [W-1:0] val_wdata,
  output logic [W-1:0] val_q,
  output logic         pin_out,
  output logic         irq
);
  localparam int CTRL_BITS = 7;

  logic [CTRL_BITS-1:0] ctrl_q;
  logic [1:0] mode, sel;
  logic ie, tov, maxd;
  logic rise, fall, match, cap_evt, cmp_evt, evt, flag, armed, out_q;

  assign ie   = ctrl_q[6];
  assign mode = ctrl_q[5:4];
  assign sel  = ctrl_q[3:2];
  assign tov  = ctrl_q[1];
  assign maxd = ctrl_q[0];

  always_ff @(posedge clk) begin
    if (!rst_n)      ctrl_q <= '0;
    else if (reg_wr) ctrl_q <= reg_wdata[CTRL_BITS-1:0];
  end

  tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(pin_in), .rise(rise), .fall(fall)
  );

  assign match   = (cnt_val == val_q);
  assign cap_evt = (mode == MD_CAPTURE) && edge_hit(sel, rise, fall);
  assign cmp_evt = (mode != MD_CAPTURE) && match;
  assign evt     = cap_evt | cmp_evt;

  always_ff @(posedge clk) begin
    if (!rst_n)       val_q <= '0;
    else if (cap_evt) val_q <= cnt_val;
    else if (val_wr)  val_q <= val_wdata;
  end

  tmr_flag_ctrl u_flag (
    .clk(clk), .rst_n(rst_n), .evt(evt), .rd(reg_rd), .wr(reg_wr),
    .wr_flag_bit(reg_wdata[7]), .flag(flag), .armed(armed)
  );

  tmr_out_ctrl u_out (
    .clk(clk), .rst_n(rst_n), .mode(mode), .sel(sel), .tov(tov), .maxd(maxd),
    .match(match), .ovf(cnt_ovf), .out_q(out_q)
  );

  assign pin_out   = drive_en(mode, sel) & out_q;
  assign reg_rdata = {flag, ctrl_q};
  assign irq       = flag & ie;
endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         reg_rd,
  input logic         reg_wr,
  input logic [7:0]   reg_wdata,
  input logic [7:0]   reg_rdata,
  input logic [W-1:0] cnt_val,
  input logic [W-1:0] val_q,
  input logic         pin_out,
  input logic         irq,
  input logic         evt,
  input logic         cap_evt,
  input logic         flag,
  input logic         armed
);
  AST_IRQ_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (reg_rdata[7] && reg_rdata[6])); // R12

  AST_EVENT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> flag); // R11

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !evt) |=> !flag); // R2

  AST_CLEAR_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !(reg_wr && !reg_wdata[7] && armed)) |=> flag); // R10

  AST_ARM_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> ($past(reg_rd) && $past(flag))); // R10

  AST_CAPTURE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (val_q == $past(cnt_val))); // R4

  AST_CAPTURE_PIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[5:4] == 2'b00) |-> !pin_out); // R6
endmodule

bind tmr_chan_unit tmr_chan_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cnt_val(cnt_val),
  .val_q(val_q), .pin_out(pin_out), .irq(irq), .evt(evt),
  .cap_evt(cap_evt), .flag(flag), .armed(armed)
);

// File: tb/test_tmr_chan_unit.sv
module test_tmr_chan_unit;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] cnt_val = 16'h0100;
  logic cnt_ovf = 1'b0, pin_in = 1'b0, reg_rd = 1'b0, reg_wr = 1'b0, val_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [W-1:0] val_wdata = '0;
  logic [W-1:0] val_q;
  logic pin_out, irq;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 1'b0;

  typedef struct {
    string       req;
    int          sel;
    logic [15:0] exp;
    int          due;
  } item_t;
  item_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_chan_unit #(.W(W)) i_tmr_chan_unit (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_ovf(cnt_ovf), .pin_in(pin_in),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .val_wr(val_wr), .val_wdata(val_wdata), .val_q(val_q), .pin_out(pin_out), .irq(irq)
  );

  function automatic logic [15:0] observe(input int sel);
    case (sel)
      0:       return {8'h00, reg_rdata};
      1:       return val_q;
      2:       return {15'd0, pin_out};
      default: return {15'd0, irq};
    endcase
  endfunction

  // monitor: compares due items in the quiet half of the clock
  always @(negedge clk) begin
    cyc++;
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      item_t it;
      logic [15:0] act;
      it = sb.pop_front();
      act = observe(it.sel);
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
      end
    end
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic expect_item(input string req, input int sel, input logic [15:0] exp);
    item_t it;
    it.req = req; it.sel = sel; it.exp = exp; it.due = cyc + 1;
    sb.push_back(it);
  endtask

  task automatic wr_ctrl(input logic [7:0] d);
    reg_wr = 1'b1; reg_wdata = d; tick(); reg_wr = 1'b0;
  endtask

  task automatic rd_ctrl();
    reg_rd = 1'b1; tick(); reg_rd = 1'b0;
  endtask

  task automatic clear_to(input logic [7:0] d);
    rd_ctrl(); wr_ctrl(d);
  endtask

  task automatic set_pin(input logic v);
    pin_in = v; tick(3);
  endtask

  task automatic hit_match();  // counter equals value register for one cycle
    cnt_val = 16'h0040; tick(); cnt_val = 16'h0100;
  endtask

  task automatic pulse_ovf();
    cnt_ovf = 1'b1; tick(); cnt_ovf = 1'b0;
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    expect_item("R1", 0, 16'h0000); expect_item("R1", 1, 16'h0000);
    expect_item("R1", 2, 16'h0000); expect_item("R1", 3, 16'h0000);
    tick();

    wr_ctrl(8'hFF);
    expect_item("R2", 0, 16'h007F); expect_item("R12", 3, 16'h0000); tick();

    // capture, rising edge
    wr_ctrl(8'h04); cnt_val = 16'h1234;
    set_pin(1'b1);
    expect_item("R3", 0, 16'h0084); expect_item("R4", 1, 16'h1234); tick();
    wr_ctrl(8'h04);
    expect_item("R10", 0, 16'h0084); tick();
    clear_to(8'h04);
    expect_item("R10", 0, 16'h0004); tick();
    cnt_val = 16'h2222; set_pin(1'b0);
    expect_item("R3", 0, 16'h0004); expect_item("R3", 1, 16'h1234); tick();

    // falling edge
    wr_ctrl(8'h08); set_pin(1'b1);
    expect_item("R3", 0, 16'h0008); tick();
    cnt_val = 16'h3333; set_pin(1'b0);
    expect_item("R3", 0, 16'h0088); expect_item("R4", 1, 16'h3333); tick();
    clear_to(8'h0C);

    // either edge
    cnt_val = 16'h4444; set_pin(1'b1);
    expect_item("R3", 0, 16'h008C); expect_item("R4", 1, 16'h4444); tick();
    clear_to(8'h0C);
    cnt_val = 16'h5555; set_pin(1'b0);
    expect_item("R3", 0, 16'h008C); expect_item("R4", 1, 16'h5555); tick();
    clear_to(8'h00);

    // no edge selected
    cnt_val = 16'h6666; set_pin(1'b1);
    expect_item("R3", 0, 16'h0000); expect_item("R3", 1, 16'h5555);
    expect_item("R6", 2, 16'h0000); tick();
    set_pin(1'b0);

    // value register write
    cnt_val = 16'h0100; val_wr = 1'b1; val_wdata = 16'h0040; tick(); val_wr = 1'b0;
    expect_item("R13", 1, 16'h0040); tick();

    // compare: set level
    wr_ctrl(8'h1C);
    expect_item("R6", 2, 16'h0000); tick();
    hit_match();
    expect_item("R6", 2, 16'h0001); expect_item("R5", 0, 16'h009C); tick();
    clear_to(8'h18);
    expect_item("R10", 0, 16'h0018); tick();
    hit_match();
    expect_item("R6", 2, 16'h0000); tick();

    // event between read and clearing write
    rd_ctrl(); hit_match(); wr_ctrl(8'h18);
    expect_item("R11", 0, 16'h0098); tick();

    // toggle on match
    clear_to(8'h14);
    hit_match();
    expect_item("R6", 2, 16'h0001); tick();
    hit_match();
    expect_item("R6", 2, 16'h0000); tick();

    // interrupt request
    wr_ctrl(8'h54);
    expect_item("R12", 3, 16'h0001); tick();
    wr_ctrl(8'h14);
    expect_item("R12", 3, 16'h0000); tick();

    // toggle on overflow
    wr_ctrl(8'h16);
    pulse_ovf();
    expect_item("R7", 2, 16'h0001); tick();
    pulse_ovf();
    expect_item("R7", 2, 16'h0000); tick();
    cnt_ovf = 1'b1; hit_match(); cnt_ovf = 1'b0;
    expect_item("R7", 2, 16'h0001); tick();
    wr_ctrl(8'h14); pulse_ovf();
    expect_item("R7", 2, 16'h0001); tick();

    // pulse-width, high at period start
    wr_ctrl(8'h28);
    hit_match();
    expect_item("R8", 2, 16'h0000); tick();
    pulse_ovf();
    expect_item("R8", 2, 16'h0001); tick();
    hit_match();
    expect_item("R8", 2, 16'h0000); tick();
    cnt_ovf = 1'b1; hit_match(); cnt_ovf = 1'b0;
    expect_item("R8", 2, 16'h0001); tick();

    // pulse-width, low at period start
    wr_ctrl(8'h2C);
    pulse_ovf();
    expect_item("R8", 2, 16'h0000); tick();
    hit_match();
    expect_item("R8", 2, 16'h0001); tick();

    // max duty
    wr_ctrl(8'h29);
    pulse_ovf(); hit_match();
    expect_item("R9", 2, 16'h0001); tick();
    wr_ctrl(8'h2D);
    pulse_ovf(); hit_match();
    expect_item("R9", 2, 16'h0000); tick();

    wr_ctrl(8'h04);
    expect_item("R6", 2, 16'h0000); tick();

    tick(3);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule